// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block is a half-duplex synchronous serial engine for clocking 8-bit words into or out of external shift registers and simple serial peripherals. It owns two pins: a data line, shown as separate input, output and output-enable signals, and a shift clock that it always drives. All timing comes from a free-running machine-cycle sequencer. The sequencer counts twelve oscillator clocks per machine cycle: six states (S1 to S6), each with two phases. Every shift and every sample happens on the S6P2 step, the last clock of a machine cycle. The shift clock therefore runs at one twelfth of the oscillator rate.

Software starts a transmit by writing the data buffer. It starts a receive by writing the control register with receive-enable set and the receive-done flag clear. Both writes are single-clock pulses. Each write is held until the next S6P2 step and takes effect there. The transmit path keeps a 9-bit shift register that is loaded with a '1' marker above the data byte and filled with zeros from the top. The transfer is over when only the marker is left to shift out. The receive path shifts each sampled bit into the MSB. When the eighth sample is in, it copies the word into a receive buffer.

Top module: `ssp_shift_port`

## Requirements
- R1: After reset, sclk=1, sdata_o=1, sdata_oe=0, tx_done=0, rx_done=0, rx_en=0 and rx_data=0. The machine-cycle position is S1P1 on the first clock after reset is released.
- R2: A transmit puts the 8 bits of the written byte on sdata_o LSB first. Each bit is stable while sclk rises, and exactly 8 sclk rising edges occur per transmit.
- R3: sclk is low only in states S3, S4 and S5 of a machine cycle in which a bit is being moved, which is clocks 4 to 9 counted from 0 at S1P1. At all other times sclk is high.
- R4: A buffer write takes effect at the first S6P2 edge at or after the write clock, call it tick T. Bit D0 is driven from tick T+1. tx_done is still 0 after tick T+8 and becomes 1 at tick T+9.
- R5: When tx_done sets, sdata_o holds 1 (the stop marker) and sdata_oe returns to 0.
- R6: A control write with ctl_ren=1 and ctl_ri=0, applied at tick T, starts a receive. sdata_i is sampled at ticks T+2 to T+9, each sample entering the MSB. rx_data and rx_done=1 appear at tick T+9.
- R7: A control write with ctl_ren=1 and ctl_ri=1 starts no receive: sclk stays high and rx_data is unchanged.
- R8: tx_done and rx_done stay set until a control write clears them. The control fields ctl_ren, ctl_ti and ctl_ri are loaded into rx_en, tx_done and rx_done at the applying tick. A hardware set on that same tick wins over a clear.
- R9: sdata_oe is 0 for the whole of a receive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously to clk |
| buf_wr | input | 1 | Single-clock data-buffer write strobe |
| buf_wdata | input | 8 | Byte to transmit |
| ctl_wr | input | 1 | Single-clock control-register write strobe |
| ctl_ren | input | 1 | Receive-enable value to write |
| ctl_ti | input | 1 | Transmit-done flag value to write |
| ctl_ri | input | 1 | Receive-done flag value to write |
| sdata_i | input | 1 | Data pin input |
| sdata_o | output | 1 | Data pin output latch |
| sdata_oe | output | 1 | Data pin drive enable |
| sclk | output | 1 | Shift clock |
| rx_data | output | 8 | Receive buffer |
| tx_done | output | 1 | Transmit-done flag |
| rx_done | output | 1 | Receive-done flag |
| rx_en | output | 1 | Receive-enable bit |

## Verification
The assertions assume a few things about the inputs. Reset is released on a clock edge. Write strobes last one clock. A receive is never requested while a transmit is in flight, and no new buffer write arrives before tx_done. Under these assumptions the checker's own twelve-clock counter stays aligned with the sequencer. The stimulus meets them by construction. Each transfer runs to its done flag and the flags are cleared before the next one starts. Random bytes and random write offsets within the machine cycle are used. The peripheral model changes sdata_i only on falling sclk, so the data is stable at every sampling edge.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_WAIT  = 2'd1,
    RX_SHIFT = 2'd2
  } rx_state_t;

  typedef struct packed {
    logic ren;
    logic ti;
    logic ri;
  } ctl_fields_t;
endpackage

// File: rtl/ssp_timing.sv
module ssp_timing #(
  parameter int STATES    = 6,
  parameter int PHASES    = 2,
  parameter int LOW_FIRST = 2,
  parameter int LOW_LAST  = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick,
  output logic low_win
);
  localparam int STEPS = STATES * PHASES;
  localparam int CW    = $clog2(STEPS);
  localparam logic [CW-1:0] LAST_STEP = CW'(STEPS - 1);
  localparam logic [CW-1:0] LOW_LO    = CW'(LOW_FIRST * PHASES);
  localparam logic [CW-1:0] LOW_HI    = CW'(LOW_LAST * PHASES + PHASES - 1);

  logic [CW-1:0] step_q, step_d;

  always_comb begin
    if (step_q == LAST_STEP) step_d = '0;
    else                     step_d = step_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= '0;
    else        step_q <= step_d;
  end

  assign tick    = (step_q == LAST_STEP);
  assign low_win = (step_q >= LOW_LO) && (step_q <= LOW_HI);
endmodule

// File: rtl/ssp_tx.sv
module ssp_tx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_data,
  output logic         pin_q,
  output logic         bit_on,
  output logic         done
);
  logic [W:0] sr_q, sr_d;
  logic       pin_d, on_d;
  logic       busy;

  assign busy = |sr_q;

  always_comb begin
    sr_d  = sr_q;
    pin_d = pin_q;
    on_d  = bit_on;
    done  = 1'b0;
    if (tick) begin
      if (load) begin
        sr_d = {1'b1, load_data};
      end else if (busy) begin
        pin_d = sr_q[0];
        sr_d  = {1'b0, sr_q[W:1]};
        on_d  = |sr_q[W:1];
        done  = ~(|sr_q[W:1]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      pin_q  <= 1'b1;
      bit_on <= 1'b0;
    end else begin
      sr_q   <= sr_d;
      pin_q  <= pin_d;
      bit_on <= on_d;
    end
  end
endmodule

// File: rtl/ssp_rx.sv
module ssp_rx
  import ssp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         start,
  input  logic         din,
  output logic         shifting,
  output logic         done,
  output logic [W-1:0] word
);
  localparam int NW = $clog2(W);
  localparam logic [NW-1:0] LAST_BIT = NW'(W - 1);

  rx_state_t      st_q, st_d;
  logic [NW-1:0]  cnt_q, cnt_d;
  logic [W-1:0]   sr_q, sr_d, word_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    sr_d   = sr_q;
    word_d = word;
    done   = 1'b0;
    if (tick) begin
      unique case (st_q)
        RX_IDLE: if (start) st_d = RX_WAIT;
        RX_WAIT: begin
          st_d  = RX_SHIFT;
          cnt_d = '0;
        end
        RX_SHIFT: begin
          sr_d  = {din, sr_q[W-1:1]};
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST_BIT) begin
            word_d = {din, sr_q[W-1:1]};
            done   = 1'b1;
            st_d   = RX_IDLE;
          end
        end
        default: st_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RX_IDLE;
      cnt_q <= '0;
      sr_q  <= '0;
      word  <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      sr_q  <= sr_d;
      word  <= word_d;
    end
  end

  assign shifting = (st_q == RX_SHIFT);
endmodule

// File: rtl/ssp_shift_port.sv
module ssp_shift_port
  import ssp_pkg::*;
#(
  parameter int W         = 8,
  parameter int STATES    = 6,
  parameter int PHASES    = 2,
  parameter int LOW_FIRST = 2,
  parameter int LOW_LAST  = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         buf_wr,
  input  logic [W-1:0] buf_wdata,
  input  logic         ctl_wr,
  input  logic         ctl_ren,
  input  logic         ctl_ti,
  input  logic         ctl_ri,
  input  logic         sdata_i,
  output logic         sdata_o,
  output logic         sdata_oe,
  output logic         sclk,
  output logic [W-1:0] rx_data,
  output logic         tx_done,
  output logic         rx_done,
  output logic         rx_en
);
  logic         tick, low_win;
  logic         tx_bit_on, tx_fin, rx_shift, rx_fin;

  // pending writes, held until the next S6P2 step
  logic         pbuf_v_q, pbuf_v_d;
  logic [W-1:0] pbuf_q, pbuf_d;
  logic         pctl_v_q, pctl_v_d;
  ctl_fields_t  pctl_q, pctl_d, ctl_eff;
  logic [W-1:0] buf_eff;
  logic         buf_apply, ctl_apply, rx_start;
  logic         ren_d, ti_d, ri_d;

  ssp_timing #(
    .STATES(STATES), .PHASES(PHASES), .LOW_FIRST(LOW_FIRST), .LOW_LAST(LOW_LAST)
  ) u_timing (
    .clk(clk), .rst_n(rst_n), .tick(tick), .low_win(low_win)
  );

  always_comb begin
    buf_eff   = buf_wr ? buf_wdata : pbuf_q;
    buf_apply = tick && (buf_wr || pbuf_v_q);
    ctl_eff   = ctl_wr ? ctl_fields_t'{ren: ctl_ren, ti: ctl_ti, ri: ctl_ri} : pctl_q;
    ctl_apply = tick && (ctl_wr || pctl_v_q);
    rx_start  = ctl_apply && ctl_eff.ren && !ctl_eff.ri;

    pbuf_v_d = pbuf_v_q;
    pbuf_d   = pbuf_q;
    if (buf_apply)   pbuf_v_d = 1'b0;
    else if (buf_wr) begin
      pbuf_v_d = 1'b1;
      pbuf_d   = buf_wdata;
    end

    pctl_v_d = pctl_v_q;
    pctl_d   = pctl_q;
    if (ctl_apply)   pctl_v_d = 1'b0;
    else if (ctl_wr) begin
      pctl_v_d = 1'b1;
      pctl_d   = ctl_eff;
    end

    ren_d = rx_en;
    ti_d  = tx_done;
    ri_d  = rx_done;
    if (ctl_apply) begin
      ren_d = ctl_eff.ren;
      ti_d  = ctl_eff.ti;
      ri_d  = ctl_eff.ri;
    end
    if (tx_fin) ti_d = 1'b1;
    if (rx_fin) ri_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pbuf_v_q <= 1'b0;
      pbuf_q   <= '0;
      pctl_v_q <= 1'b0;
      pctl_q   <= '0;
      rx_en    <= 1'b0;
      tx_done  <= 1'b0;
      rx_done  <= 1'b0;
    end else begin
      pbuf_v_q <= pbuf_v_d;
      pbuf_q   <= pbuf_d;
      pctl_v_q <= pctl_v_d;
      pctl_q   <= pctl_d;
      rx_en    <= ren_d;
      tx_done  <= ti_d;
      rx_done  <= ri_d;
    end
  end

  ssp_tx #(.W(W)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(buf_apply), .load_data(buf_eff),
    .pin_q(sdata_o), .bit_on(tx_bit_on), .done(tx_fin)
  );

  ssp_rx #(.W(W)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(rx_start), .din(sdata_i),
    .shifting(rx_shift), .done(rx_fin), .word(rx_data)
  );

  assign sdata_oe = tx_bit_on;
  assign sclk     = ~((tx_bit_on || rx_shift) && low_win);
endmodule

// File: rtl/ssp_shift_port_chk.sv
module ssp_shift_port_chk #(
  parameter int STEPS = 12
) (
  input logic clk,
  input logic rst_n,
  input logic sclk,
  input logic sdata_o,
  input logic sdata_oe,
  input logic tx_done,
  input logic rx_done,
  input logic rx_shift,
  input logic ctl_apply
);
  localparam int CW = $clog2(STEPS);
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);
  logic [CW-1:0] pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           pos <= '0;
    else if (pos == LAST) pos <= '0;
    else                  pos <= pos + 1'b1;
  end

  // R3: shift clock low only inside states S3..S5
  assert_sclk_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk |-> (pos >= CW'(4) && pos <= CW'(9)));

  // R4: transmit-done only sets on an S6P2 step
  assert_tx_done_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> (pos == '0));

  // R6: receive-done only sets on an S6P2 step
  assert_rx_done_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_done) |-> (pos == '0));

  // R5: the stop marker is on the pin and drive released when transmit ends
  assert_stop_marker_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> (sdata_o && !sdata_oe));

  // R8: flags hold unless a control write is applied
  assert_tx_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !ctl_apply) |=> tx_done);
  assert_rx_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !ctl_apply) |=> rx_done);

  // R9: pin not driven while receiving
  assert_no_drive_rx_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_shift |-> !sdata_oe);
endmodule

bind ssp_shift_port ssp_shift_port_chk #(.STEPS(STATES * PHASES)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata_o(sdata_o), .sdata_oe(sdata_oe),
  .tx_done(tx_done), .rx_done(rx_done), .rx_shift(rx_shift), .ctl_apply(ctl_apply)
);

// File: tb/ssp_shift_port_tb.sv
`timescale 1ns/1ps
module ssp_shift_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       buf_wr = 1'b0;
  logic [7:0] buf_wdata = 8'h00;
  logic       ctl_wr = 1'b0, ctl_ren = 1'b0, ctl_ti = 1'b0, ctl_ri = 1'b0;
  logic       sdata_i = 1'b0;
  logic       sdata_o, sdata_oe, sclk, tx_done, rx_done, rx_en;
  logic [7:0] rx_data;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  ssp_shift_port u_dut (
    .clk(clk), .rst_n(rst_n), .buf_wr(buf_wr), .buf_wdata(buf_wdata),
    .ctl_wr(ctl_wr), .ctl_ren(ctl_ren), .ctl_ti(ctl_ti), .ctl_ri(ctl_ri),
    .sdata_i(sdata_i), .sdata_o(sdata_o), .sdata_oe(sdata_oe), .sclk(sclk),
    .rx_data(rx_data), .tx_done(tx_done), .rx_done(rx_done), .rx_en(rx_en)
  );

  // bench view of the machine-cycle position (0 = S1P1)
  int pos = 0;
  always @(posedge clk) begin
    if (!rst_n)        pos <= 0;
    else if (pos == 11) pos <= 0;
    else               pos <= pos + 1;
  end

  // peripheral model and pin monitor
  logic        prev_sclk = 1'b1;
  int          falls = 0;
  int          rises = 0;
  int          win_bad = 0;
  int          oe_bad = 0;
  logic [63:0] cap_hist = '0;
  logic [7:0]  rx_word = 8'h00;
  int          rx_base = 0;
  bit          rx_mode = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_sclk && !sclk) begin
        if (rx_mode) sdata_i <= rx_word[(falls - rx_base) & 7];
        falls <= falls + 1;
      end
      if (!prev_sclk && sclk) begin
        cap_hist <= {sdata_o, cap_hist[63:1]};
        rises <= rises + 1;
      end
      if (!sclk && !(pos >= 4 && pos <= 9)) win_bad <= win_bad + 1;
      if (rx_mode && sdata_oe) oe_bad <= oe_bad + 1;
    end
    prev_sclk <= sclk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_tick();
    while (pos != 0) @(negedge clk);
  endtask

  task automatic wait_mc();
    repeat (12) @(negedge clk);
  endtask

  task automatic ctl_write(input bit ren, input bit ti, input bit ri);
    ctl_ren = ren; ctl_ti = ti; ctl_ri = ri; ctl_wr = 1'b1;
    @(negedge clk);
    ctl_wr = 1'b0;
    wait_tick();
  endtask

  task automatic do_tx(input logic [7:0] w, input int skew);
    int f0;
    int r0;
    repeat (skew) @(negedge clk);
    f0 = falls; r0 = rises;
    buf_wdata = w; buf_wr = 1'b1;
    @(negedge clk);
    buf_wr = 1'b0;
    wait_tick();
    repeat (8) wait_mc();
    chk(tx_done == 1'b0, "R4 tx_done early", tx_done, 0);
    wait_mc();
    chk(tx_done == 1'b1, "R4 tx_done at T+9", tx_done, 1);
    chk(sdata_o == 1'b1 && sdata_oe == 1'b0, "R5 marker/release", {sdata_o, sdata_oe}, 2);
    chk(cap_hist[63:56] == w, "R2 tx word", cap_hist[63:56], w);
    chk(rises - r0 == 8, "R2 sclk rising edges", rises - r0, 8);
    chk(falls - f0 == 8, "R3 sclk pulses", falls - f0, 8);
    wait_mc(); wait_mc();
    chk(tx_done == 1'b1, "R8 tx_done sticky", tx_done, 1);
    ctl_write(1'b0, 1'b0, 1'b0);
    chk(tx_done == 1'b0, "R8 tx_done cleared", tx_done, 0);
  endtask

  task automatic do_rx(input logic [7:0] w, input int skew);
    repeat (skew) @(negedge clk);
    rx_word = w; rx_base = falls; rx_mode = 1'b1;
    ctl_write(1'b1, 1'b0, 1'b0);
    chk(rx_en == 1'b1, "R8 rx_en loaded", rx_en, 1);
    repeat (8) wait_mc();
    chk(rx_done == 1'b0, "R6 rx_done early", rx_done, 0);
    wait_mc();
    chk(rx_done == 1'b1, "R6 rx_done at T+9", rx_done, 1);
    chk(rx_data == w, "R6 rx word", rx_data, w);
    chk(falls - rx_base == 8, "R6 sclk pulses", falls - rx_base, 8);
    rx_mode = 1'b0;
    ctl_write(1'b0, 1'b0, 1'b0);
    chk(rx_done == 1'b0, "R8 rx_done cleared", rx_done, 0);
  endtask

  task automatic finish_run();
    chk(win_bad == 0, "R3 sclk low outside S3-S5", win_bad, 0);
    chk(oe_bad == 0, "R9 drive during receive", oe_bad, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] keep;
    int f0;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sclk == 1'b1 && sdata_o == 1'b1 && sdata_oe == 1'b0, "R1 pins",
        {sclk, sdata_o, sdata_oe}, 6);
    chk(tx_done == 0 && rx_done == 0 && rx_en == 0 && rx_data == 8'h00, "R1 flags",
        {tx_done, rx_done, rx_en, rx_data}, 0);

    // directed transmit corners
    do_tx(8'h00, 0);
    do_tx(8'hFF, 3);
    do_tx(8'hA5, 11);
    for (int i = 0; i < 6; i++) do_tx(8'($urandom), int'($urandom % 16));

    // directed receive corners
    do_rx(8'h01, 0);
    do_rx(8'h80, 7);
    for (int i = 0; i < 6; i++) do_rx(8'($urandom), int'($urandom % 16));

    // receive blocked while the done flag is written set (R7)
    keep = rx_data;
    f0 = falls;
    ctl_write(1'b1, 1'b0, 1'b1);
    repeat (11) wait_mc();
    chk(falls == f0 && sclk == 1'b1, "R7 no shift clock", falls - f0, 0);
    chk(rx_data == keep, "R7 rx_data unchanged", rx_data, keep);
    chk(rx_done == 1'b1, "R7/R8 flag as written", rx_done, 1);
    ctl_write(1'b0, 1'b0, 1'b0);
    chk(rx_done == 1'b0 && rx_en == 1'b0, "R8 clear all", {rx_done, rx_en}, 0);

    finish_run();
  end
endmodule